// File: doc/BRIEF.md
# Serial-in parallel-out shifter with output latch

This block accepts a serial bit stream into a chain of shift stages, one bit per rising edge of a shift clock. A separate holding register, clocked by its own storage clock, copies the whole chain in one step and drives the parallel outputs. While new data is being shifted in, the parallel outputs keep showing the last committed word.

Each of the two registers has its own asynchronous active-low clear. The last shift stage is also brought out as a cascade bit. Connecting it to the serial input of a second unit builds a wider chain. When both units share the two clocks, they commit together.

Top module: `sipo_latched_shifter`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 0 loads `ser_in` and every stage i (i > 0) loads the previous value of stage i-1.
- R2: While `shift_clr_n` is low, all shift stages are 0, whatever `shift_clk` does. The clear does not touch `par_q`.
- R3: On each rising edge of `store_clk`, `par_q` takes the values all shift stages had just before that edge.
- R4: While `store_clr_n` is low, `par_q` is 0. The shift stages are kept, so a later storage edge puts them back on `par_q`.
- R5: `cascade_out` equals the last shift stage (stage WIDTH-1). It follows shift edges without any storage edge.
- R6: `par_q` changes only on a storage edge or a storage clear. Shift edges alone leave it unchanged.
- R7: When both clocks rise together, `par_q` receives the shift contents from before that edge, so the storage register stays one shift behind.
- R8: With no clock edge and no active clear, both registers hold their state.
- R9: Bit order: `par_q[i]` is shift stage i. The first bit shifted in reaches `par_q[WIDTH-1]` after WIDTH shifts and one storage edge.
- R10: Two units in a chain (cascade of the first to `ser_in` of the second, with shared clocks) hold a 2*WIDTH-bit stream after 2*WIDTH shifts and one storage edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| store_clk | input | 1 | Storage clock, rising edge |
| store_clr_n | input | 1 | Asynchronous clear of the storage register, active low |
| par_q | output | WIDTH | Parallel outputs from the storage register |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The case hardest to reach from the ports is a storage clear that wipes `par_q` while the shift stages still hold data. The only proof that the data survived comes later, when `cascade_out` is checked and a storage edge with no shift edge restores the word. The stimulus shifts a known word, pulses the storage clear between shift sequences, checks that `par_q` reads zero and the cascade bit is unchanged, and then issues a lone storage edge. Tied-clock edges and a two-unit chain cover the one-shift lag and the bit order across units.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int SIPO_WIDTH_DEFAULT = 8;

  // index of the stage that feeds stage idx; -1 means the serial input
  function automatic int feeder_of(input int idx);
    return idx - 1;
  endfunction
endpackage

// File: rtl/sipo_stage.sv
module sipo_stage (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int WIDTH = sipo_pkg::SIPO_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             din,
  output logic [WIDTH-1:0] stages
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_stage
      logic d_in;
      if (sipo_pkg::feeder_of(g) < 0) begin : g_head
        assign d_in = din;
      end else begin : g_body
        assign d_in = stages[sipo_pkg::feeder_of(g)];
      end
      sipo_stage u_ff (
        .clk  (clk),
        .clr_n(clr_n),
        .d    (d_in),
        .q    (stages[g])
      );
    end
  endgenerate
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int WIDTH = sipo_pkg::SIPO_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/sipo_latched_shifter.sv
module sipo_latched_shifter #(
  parameter int WIDTH = sipo_pkg::SIPO_WIDTH_DEFAULT
) (
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             shift_clr_n,
  input  logic             store_clk,
  input  logic             store_clr_n,
  output logic [WIDTH-1:0] par_q,
  output logic             cascade_out
);
  localparam int LAST = WIDTH - 1;

  // shift stage contents, named for the checker
  logic [WIDTH-1:0] shift_q;

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk   (shift_clk),
    .clr_n (shift_clr_n),
    .din   (ser_in),
    .stages(shift_q)
  );

  sipo_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk  (store_clk),
    .clr_n(store_clr_n),
    .d    (shift_q),
    .q    (par_q)
  );

  assign cascade_out = shift_q[LAST];
endmodule

// File: rtl/sipo_latched_shifter_chk.sv
module sipo_latched_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             ser_in,
  input logic             shift_clk,
  input logic             shift_clr_n,
  input logic             store_clk,
  input logic             store_clr_n,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] par_q
);
  // R1: each shift edge moves the chain by one and takes in the serial bit
  p_shift_step_r1: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
    1'b1 |=> (shift_q[0] == $past(ser_in)) &&
             (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])));

  // R2: a held shift clear keeps the stages at zero across shift edges
  p_shift_clear_r2: assert property (@(posedge shift_clk) disable iff (shift_clr_n)
    1'b1 |-> (shift_q == '0));

  // R3: a storage edge commits the pre-edge chain contents
  p_store_copy_r3: assert property (@(posedge store_clk) disable iff (!store_clr_n)
    1'b1 |=> (par_q == $past(shift_q)));

  // R4: a held storage clear keeps the outputs at zero
  p_store_clear_r4: assert property (@(posedge store_clk) disable iff (store_clr_n)
    1'b1 |-> (par_q == '0));
endmodule

bind sipo_latched_shifter sipo_latched_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .ser_in     (ser_in),
  .shift_clk  (shift_clk),
  .shift_clr_n(shift_clr_n),
  .store_clk  (store_clk),
  .store_clr_n(store_clr_n),
  .shift_q    (shift_q),
  .par_q      (par_q)
);

// File: tb/sipo_latched_shifter_test.sv
`timescale 1ns/1ps
module sipo_latched_shifter_test;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] p1;
    logic [W-1:0] p2;
    logic         c1;
    logic         c2;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
  logic shift_clr_n = 1'b0, store_clr_n = 1'b0;
  logic [W-1:0] par1, par2;
  logic casc1, casc2;

  sipo_latched_shifter #(.WIDTH(W)) uut (
    .ser_in(ser_in), .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
    .store_clk(store_clk), .store_clr_n(store_clr_n),
    .par_q(par1), .cascade_out(casc1));

  sipo_latched_shifter #(.WIDTH(W)) uut2 (
    .ser_in(casc1), .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
    .store_clk(store_clk), .store_clr_n(store_clr_n),
    .par_q(par2), .cascade_out(casc2));

  // reference model
  logic [W-1:0] m_sh1 = '0, m_sh2 = '0, m_st1 = '0, m_st2 = '0;
  exp_t q[$];
  event chk_ev;
  int vectors = 0, miscompares = 0;

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (par1 !== e.p1 || par2 !== e.p2 || casc1 !== e.c1 || casc2 !== e.c2) begin
          miscompares++;
          $display("FAIL %s: par=%h/%h casc=%b/%b expected par=%h/%h casc=%b/%b",
                   e.tag, par1, par2, casc1, casc2, e.p1, e.p2, e.c1, e.c2);
        end
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.p1 = m_st1; e.p2 = m_st2; e.c1 = m_sh1[W-1]; e.c2 = m_sh2[W-1]; e.tag = tag;
    q.push_back(e);
    #0.5;
    -> chk_ev;
    #0.5;
  endtask

  // one edge on the chosen clocks, away from the bench clock edge
  task automatic pulse(input bit s, input bit r, input bit din);
    logic [W-1:0] o1, o2;
    @(posedge clk);
    ser_in = din;
    #1;
    o1 = m_sh1; o2 = m_sh2;
    shift_clk = s; store_clk = r;
    if (r) begin
      if (store_clr_n) begin m_st1 = o1; m_st2 = o2; end
    end
    if (s && shift_clr_n) begin
      m_sh1 = {o1[W-2:0], din};
      m_sh2 = {o2[W-2:0], o1[W-1]};
    end
    #1;
    shift_clk = 1'b0; store_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [W-1:0] w, input string tag);
    for (int i = W - 1; i >= 0; i--) begin
      pulse(1'b1, 1'b0, w[i]);
      expect_now(tag);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : driver
    #3;
    expect_now("R2 R4 reset state");
    @(posedge clk); #1;
    shift_clr_n = 1'b1; store_clr_n = 1'b1;
    expect_now("R8 after clear release");

    // R9: a single 1 followed by zeros lands on the top output bit
    pulse(1'b1, 1'b0, 1'b1);
    for (int i = 1; i < W; i++) pulse(1'b1, 1'b0, 1'b0);
    expect_now("R5 R6 cascade after 8 shifts, outputs unchanged");
    pulse(1'b0, 1'b1, 1'b0);
    expect_now("R9 first bit on top output");
    if (par1 !== 8'h80) begin
      miscompares++;
      $display("FAIL R9: par=%h expected=%h", par1, 8'h80);
    end
    vectors++;

    // R1 R5 R6: shift a word bit by bit, outputs stay put
    shift_word(8'hB4, "R1 R5 R6 shift B4");
    pulse(1'b0, 1'b1, 1'b0);
    expect_now("R3 store B4");

    // R8: idle time, nothing moves
    repeat (20) @(posedge clk);
    expect_now("R8 hold without edges");

    // R4: storage clear mid sequence keeps shift data
    shift_word(8'h3C, "R1 shift 3C");
    @(posedge clk); #1;
    store_clr_n = 1'b0; m_st1 = '0; m_st2 = '0;
    expect_now("R4 storage clear zeros outputs");
    pulse(1'b0, 1'b1, 1'b0);
    expect_now("R4 storage edge ignored while cleared");
    @(posedge clk); #1;
    store_clr_n = 1'b1;
    expect_now("R4 cascade kept after storage clear");
    pulse(1'b0, 1'b1, 1'b0);
    expect_now("R4 outputs restored by storage edge");

    // R2: shift clear overrides shift edges, storage untouched
    @(posedge clk); #1;
    shift_clr_n = 1'b0; m_sh1 = '0; m_sh2 = '0;
    expect_now("R2 shift clear zeros cascade, outputs kept");
    pulse(1'b1, 1'b0, 1'b1);
    expect_now("R2 shift edge ignored under clear");
    @(posedge clk); #1;
    shift_clr_n = 1'b1;
    pulse(1'b0, 1'b1, 1'b0);
    expect_now("R2 cleared chain stored");

    // R7: tied clocks, storage lags one shift
    for (int i = 0; i < 10; i++) begin
      pulse(1'b1, 1'b1, (i % 3) == 0);
      expect_now("R7 tied clocks one shift behind");
    end

    // R10: 16-bit stream across two units
    shift_word(8'hA5, "R10 cascade upper byte");
    shift_word(8'h1E, "R10 cascade lower byte");
    pulse(1'b0, 1'b1, 1'b0);
    expect_now("R10 two-unit word");
    if (par2 !== 8'hA5 || par1 !== 8'h1E) begin
      miscompares++;
      $display("FAIL R10: par=%h%h expected=%h%h", par2, par1, 8'hA5, 8'h1E);
    end
    vectors++;

    #10;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule